// File: doc/BRIEF.md
# Supply-Fail Write-Protect Supervisor

This block watches the supply rail of a battery-backed static memory. It works from digitised comparator flags and drives the memory's control side. When the supply sags below the write-protect trip level, it locks out writes and asks for the data pins to be tristated. When the supply drops further, below the switch-over level (about 3 V), it connects the backup battery to the array. On the way back up it hands the array back to the external supply. It then holds the lock for a timed recovery interval, counted in ticks of a millisecond-rate strobe, before it declares the memory ready.

Two trip levels exist: the 4.75 V-class option and the 4.5 V-class option. Each comes in as its own comparator flag, and a parameter picks which one is obeyed. A one-time seal keeps the battery disconnected from reset until the supply has risen above the trip level once. Every comparator flag passes through a two-flop synchroniser before the state machine uses it. An input change therefore reaches the outputs on the third rising clock edge.

Top module: `supply_guard`

## Requirements
- R1: After reset the block is sealed: wr_lock=1, out_float=1, batt_link=0, mem_ready=0.
- R2: While sealed, a low switch-over flag (sw_above_a=0) leaves batt_link at 0.
- R3: The first time the selected trip flag is seen high, the seal breaks and recovery starts. wr_lock and out_float stay 1 and mem_ready stays 0 until RECOVER_TICKS tick pulses have been counted in recovery.
- R4: In normal operation the outputs are wr_lock=0, out_float=0, batt_link=0 and mem_ready=1.
- R5: The selected trip flag going low sets wr_lock=1 and out_float=1 and clears mem_ready on the third rising clock edge after the change. The outputs keep their old values through the second edge.
- R6: Once the seal is broken, sw_above_a=0 sets batt_link=1. sw_above_a returning to 1 clears it again.
- R7: If the selected trip flag drops during recovery, the tick count restarts from zero. The next recovery again needs the full RECOVER_TICKS ticks.
- R8: TRIP_SEL=0 obeys trip_hi_a and ignores trip_lo_a. TRIP_SEL=1 does the reverse. The unselected flag has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at the recovery time base |
| trip_hi_a | input | 1 | Supply above the upper trip level (asynchronous) |
| trip_lo_a | input | 1 | Supply above the lower trip level (asynchronous) |
| sw_above_a | input | 1 | Supply above the battery switch-over level (asynchronous) |
| wr_lock | output | 1 | Write protect; gates chip and write enables inactive |
| out_float | output | 1 | Request to tristate the memory data outputs |
| batt_link | output | 1 | Connect the battery to the array |
| mem_ready | output | 1 | Memory fully operational |

## Verification
The hardest case to reach is a recovery interrupted part-way through and then repeated. A wrong design that kept its count would finish early, and that shows only in the tick count of the second attempt. The vector walk leaves recovery three ticks in, out of four, by dropping the trip flag. It then returns and gives three more ticks, and expects the lock still set. The stimulus also holds the unselected trip flag high while sealed, and later low while running, to show that it is ignored.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [2:0] {
    ST_SEALED  = 3'd0,
    ST_NORMAL  = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BATTERY = 3'd3,
    ST_RECOVER = 3'd4
  } guard_state_t;

  // True when the count sits on the final tick of an interval of n ticks.
  function automatic logic is_last_tick(input int cnt, input int n);
    return cnt == (n - 1);
  endfunction

  // Next state from synchronised flags and the recovery expiry event.
  function automatic guard_state_t next_state(input guard_state_t cur,
                                              input logic trip_ok,
                                              input logic sw_ok,
                                              input logic expired);
    guard_state_t nxt;
    nxt = cur;
    case (cur)
      ST_SEALED:  if (trip_ok) nxt = ST_RECOVER;
      ST_NORMAL:  if (!trip_ok) nxt = sw_ok ? ST_PROTECT : ST_BATTERY;
      ST_PROTECT: if (!sw_ok) nxt = ST_BATTERY;
                  else if (trip_ok) nxt = ST_RECOVER;
      ST_BATTERY: if (sw_ok) nxt = trip_ok ? ST_RECOVER : ST_PROTECT;
      ST_RECOVER: if (!trip_ok) nxt = sw_ok ? ST_PROTECT : ST_BATTERY;
                  else if (expired) nxt = ST_NORMAL;
      default:    nxt = ST_SEALED;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_a,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b0;
        stable <= 1'b0;
      end else begin
        meta   <= d_a[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/sg_recov_timer.sv
module sg_recov_timer #(
  parameter int TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  import sg_pkg::*;
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;

  assign expired = run && tick && is_last_tick(int'(cnt), TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (expired)  cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end

  // R7: leaving recovery clears the count, so a new recovery starts fresh
  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < TICKS);
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_ok,
  input  logic sw_ok,
  input  logic expired,
  output logic run,
  output logic wr_lock,
  output logic out_float,
  output logic batt_link,
  output logic mem_ready
);
  import sg_pkg::*;

  guard_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SEALED;
    else        state <= next_state(state, trip_ok, sw_ok, expired);
  end

  always_comb begin
    run       = (state == ST_RECOVER);
    mem_ready = (state == ST_NORMAL);
    wr_lock   = !mem_ready;
    out_float = !mem_ready;
    batt_link = (state == ST_BATTERY);
  end

  // R5: a synchronised trip loss locks writes by the next edge
  assert_lock_on_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_ok |=> (wr_lock && out_float && !mem_ready));
  // R6: battery connected only after the switch-over flag was seen low
  assert_batt_low_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    batt_link |-> !$past(sw_ok));
  // R3: readiness only follows an expired recovery interval
  assert_ready_after_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(expired));
  // R2: the sealed state never hands the array to the battery
  assert_seal_no_batt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEALED) |=> !batt_link);
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int TRIP_SEL      = 0,
  parameter int RECOVER_TICKS = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trip_hi_a,
  input  logic trip_lo_a,
  input  logic sw_above_a,
  output logic wr_lock,
  output logic out_float,
  output logic batt_link,
  output logic mem_ready
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0] flags_s;
  logic trip_ok, sw_ok, run, expired;

  sg_sync #(.WIDTH(NFLAG)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_a({sw_above_a, trip_lo_a, trip_hi_a}),
    .q(flags_s)
  );

  // R8: the parameter picks which trip comparator is obeyed
  assign trip_ok = (TRIP_SEL == 0) ? flags_s[0] : flags_s[1];
  assign sw_ok   = flags_s[2];

  sg_recov_timer #(.TICKS(RECOVER_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .expired(expired)
  );

  sg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .trip_ok(trip_ok), .sw_ok(sw_ok),
    .expired(expired), .run(run), .wr_lock(wr_lock), .out_float(out_float),
    .batt_link(batt_link), .mem_ready(mem_ready)
  );

  // R4: ready means every protective output is released
  assert_ready_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> (!wr_lock && !out_float && !batt_link));
endmodule

// File: tb/supply_guard_tb.sv
module supply_guard_tb;
  localparam int NT = 4;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hi = 1'b0, lo = 1'b0, sw = 1'b0;
  logic wr_lock, out_float, batt_link, mem_ready;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  supply_guard #(.TRIP_SEL(0), .RECOVER_TICKS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trip_hi_a(hi), .trip_lo_a(lo),
    .sw_above_a(sw), .wr_lock(wr_lock), .out_float(out_float),
    .batt_link(batt_link), .mem_ready(mem_ready)
  );

  // {hi, lo, sw, ticks[2:0], lock, float, batt, ready}
  localparam logic [9:0] VEC [NV] = '{
    10'b010_000_1100, // 0  R8 lower flag ignored while sealed
    10'b000_000_1100, // 1  R2 sealed, no battery
    10'b111_011_1100, // 2  R3 recovery, 3 of 4 ticks
    10'b111_001_0001, // 3  R3 R4 fourth tick -> ready
    10'b011_000_1100, // 4  R5 trip lost -> protect
    10'b000_000_1110, // 5  R6 below switch-over -> battery
    10'b001_000_1100, // 6  R6 back above switch-over
    10'b111_011_1100, // 7  R7 recovery 3 ticks
    10'b011_000_1100, // 8  R7 interrupted
    10'b111_011_1100, // 9  R7 count restarted, still locked
    10'b111_001_0001, // 10 R7 full interval -> ready
    10'b101_000_0001, // 11 R8 lower flag ignored while running
    10'b000_000_1110  // 12 R6 straight to battery
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 11:        return "R8";
      1:            return "R2";
      2, 3:         return "R3";
      4:            return "R5";
      5, 6, 12:     return "R6";
      default:      return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {wr_lock, out_float, batt_link, mem_ready};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: outputs lock/float/batt/ready got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 4'b1100);

    for (int i = 0; i < NV; i++) begin
      {hi, lo, sw} = VEC[i][9:7];
      repeat (4) @(negedge clk);
      pulse_ticks(int'(VEC[i][6:4]));
      chk(tag_of(i), VEC[i][3:0]);
    end

    // R5 latency: restore, then drop trip and watch edge by edge
    {hi, lo, sw} = 3'b111;
    repeat (4) @(negedge clk);
    pulse_ticks(NT);
    chk("R4", 4'b0001);
    hi = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5", 4'b0001);
    @(negedge clk);
    chk("R5", 4'b1100);

    // R1 again: mid-run reset returns to sealed state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 4'b1100);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule